// File: doc/BRIEF.md
# Unlock-cycle flash command sequencer

This block sits between a host and a parallel NOR flash bank that takes commands only after a two-write unlock preamble. On a one-cycle start pulse it runs one of two operations against the array: a program of one data word, or the erase of one sector. It produces the full command sequence on a simple synchronous bus. That bus carries an address, write data, a write strobe, a read strobe, and read data that returns one cycle after the read strobe.

After issuing the commands, the block polls the array by reading the target address. Completion is judged on bit 7 of every byte lane of the read-back. A program has finished when each lane's bit 7 matches bit 7 of the written data. An erase has finished when every lane's bit 7 reads as one. Each operation has its own poll budget, given as a parameter. When that budget runs out, the block writes the reset command to the target address and reports a timeout.

Before any program command, the block reads the target word. If the new data would need a zero bit turned back to one, it gives up and sends nothing to the array. Each command byte is copied into the low byte of every bus lane. The result is one error code with a one-cycle done pulse.

Top module: `flash_cmd_seq`

## Requirements
- R1: While in reset and directly after reset, busy, done, fl_we and fl_re are 0 and err_code is 0. Whenever busy is 0, neither bus strobe is asserted.
- R2: A program writes these four words on four consecutive cycles, with each command byte in the low 8 bits of every 16-bit lane:
  - 0x00AA00AA to CYC1_ADDR (0x0555);
  - 0x00550055 to CYC2_ADDR (0x02AA);
  - 0x00A000A0 to CYC1_ADDR;
  - the data word to the target address.
- R3: An erase writes these six words on six consecutive cycles, in this order:
  - 0x00AA00AA to CYC1_ADDR;
  - 0x00550055 to CYC2_ADDR;
  - 0x00800080 to CYC1_ADDR;
  - 0x00AA00AA to CYC1_ADDR;
  - 0x00550055 to CYC2_ADDR;
  - 0x00300030 to the target address.
- R4: A program first makes one read of the target address. If (current AND new) differs from new, the operation ends with err_code 2 and no write at all.
- R5: A program ends with err_code 0 and no further write on the first poll where bit 7 of each lane (bits 7 and 23) equals the same bit of the data word.
- R6: An erase ends when bits 7 and 23 of a poll read are both 1. The block then writes 0x00F000F0 to the target address and finishes with err_code 0.
- R7: If PROG_LIMIT polls (for a program) or ERASE_LIMIT polls (for an erase) all fail, the block writes 0x00F000F0 to the target address and ends with err_code 1. Exactly that many poll reads take place.
- R8: When the last permitted poll shows completion, completion wins and the err_code is 0.
- R9: A start pulse while busy is 1 is ignored. It causes no extra write and starts no operation afterwards.
- R10: done is a one-cycle pulse with busy at 0. err_code keeps its value until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | One-cycle request, accepted while busy and done are 0 |
| op_erase | input | 1 | 0 = program word, 1 = sector erase |
| tgt_addr | input | ADDR_W | Target word or sector address |
| tgt_data | input | DATA_W | Word to program |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err_code | output | 2 | 0 ok, 1 timeout, 2 not erased |
| fl_addr | output | ADDR_W | Flash bus address |
| fl_wdata | output | DATA_W | Flash bus write data |
| fl_we | output | 1 | Flash write strobe |
| fl_re | output | 1 | Flash read strobe |
| fl_rdata | input | DATA_W | Flash read data, valid the cycle after fl_re |

## Verification
Completion detection and poll-budget expiry can fall on the same poll read. This happens when the array turns ready exactly on the last permitted read.

The bench's behavioural flash model stays busy for a programmable number of reads. Setting that number to one below each limit provokes the collision. The result must be err_code 0 with exactly limit poll reads and no reset write after a program.

Setting the number to the limit itself gives the opposite outcome: a timeout, the reset write, and the same read count.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PRE_RD, ST_PRE_CHK, ST_CMD,
    ST_POLL_RD, ST_POLL_CHK, ST_RST_WR, ST_FIN
  } seq_state_e;

  typedef enum logic [1:0] {AS_CYC1, AS_CYC2, AS_TGT} addr_sel_e;

  typedef struct packed {
    addr_sel_e   asel;
    logic        use_data;
    logic [7:0]  code;
  } cmd_step_t;

  localparam int unsigned STEP_W = 3;
  localparam logic [STEP_W-1:0] PROG_LAST  = 3'd3;
  localparam logic [STEP_W-1:0] ERASE_LAST = 3'd5;

  localparam logic [7:0] CODE_UNLK_A = 8'hAA;
  localparam logic [7:0] CODE_UNLK_B = 8'h55;
  localparam logic [7:0] CODE_PROG   = 8'hA0;
  localparam logic [7:0] CODE_ERMODE = 8'h80;
  localparam logic [7:0] CODE_SECT   = 8'h30;
  localparam logic [7:0] CODE_RESET  = 8'hF0;

  localparam logic [1:0] ERR_NONE       = 2'd0;
  localparam logic [1:0] ERR_TIMEOUT    = 2'd1;
  localparam logic [1:0] ERR_NOT_ERASED = 2'd2;

  function automatic cmd_step_t step_lookup(input logic is_erase,
                                            input logic [STEP_W-1:0] step);
    cmd_step_t s;
    s = '{asel: AS_CYC1, use_data: 1'b0, code: CODE_UNLK_A};
    if (!is_erase) begin
      case (step)
        3'd1:    s = '{asel: AS_CYC2, use_data: 1'b0, code: CODE_UNLK_B};
        3'd2:    s = '{asel: AS_CYC1, use_data: 1'b0, code: CODE_PROG};
        3'd3:    s = '{asel: AS_TGT,  use_data: 1'b1, code: 8'h00};
        default: s = '{asel: AS_CYC1, use_data: 1'b0, code: CODE_UNLK_A};
      endcase
    end else begin
      case (step)
        3'd1:    s = '{asel: AS_CYC2, use_data: 1'b0, code: CODE_UNLK_B};
        3'd2:    s = '{asel: AS_CYC1, use_data: 1'b0, code: CODE_ERMODE};
        3'd3:    s = '{asel: AS_CYC1, use_data: 1'b0, code: CODE_UNLK_A};
        3'd4:    s = '{asel: AS_CYC2, use_data: 1'b0, code: CODE_UNLK_B};
        3'd5:    s = '{asel: AS_TGT,  use_data: 1'b0, code: CODE_SECT};
        default: s = '{asel: AS_CYC1, use_data: 1'b0, code: CODE_UNLK_A};
      endcase
    end
    return s;
  endfunction

endpackage

// File: rtl/fseq_rst_sync.sv
module fseq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/fseq_poll_timer.sv
module fseq_poll_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  input  logic [CNT_W-1:0] limit,
  output logic             last_poll
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign cnt_en = clr | inc;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)      cnt_d = '0;
    else if (inc) cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // the poll under evaluation is the limit-th one since polling began
  assign last_poll = (cnt_q == (limit - CNT_W'(1)));
endmodule

// File: rtl/fseq_lane_check.sv
module fseq_lane_check #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LANE_W = 16
) (
  input  logic [DATA_W-1:0] rdata,
  input  logic [DATA_W-1:0] wdata,
  output logic              prog_match,
  output logic              erase_match,
  output logic              erased_ok
);
  localparam int unsigned LANES = DATA_W / LANE_W;

  logic [LANES-1:0] lane_eq, lane_set;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_eq[l]  = (rdata[l*LANE_W + 7] == wdata[l*LANE_W + 7]);
    assign lane_set[l] = rdata[l*LANE_W + 7];
  end

  assign prog_match  = &lane_eq;
  assign erase_match = &lane_set;
  assign erased_ok   = ((rdata & wdata) == wdata);
endmodule

// File: rtl/fseq_ctrl.sv
module fseq_ctrl
  import flash_seq_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned LANE_W    = 16,
  parameter logic [ADDR_W-1:0] CYC1_ADDR = 'h0555,
  parameter logic [ADDR_W-1:0] CYC2_ADDR = 'h02AA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              op_erase,
  input  logic [ADDR_W-1:0] tgt_addr,
  input  logic [DATA_W-1:0] tgt_data,
  input  logic              prog_match,
  input  logic              erase_match,
  input  logic              erased_ok,
  input  logic              last_poll,
  output logic              tmr_clr,
  output logic              tmr_inc,
  output logic              op_q,
  output logic [DATA_W-1:0] data_q,
  output logic [ADDR_W-1:0] fl_addr,
  output logic [DATA_W-1:0] fl_wdata,
  output logic              fl_we,
  output logic              fl_re,
  output logic              busy,
  output logic              done,
  output logic [1:0]        err_code
);
  localparam int unsigned LANES = DATA_W / LANE_W;

  seq_state_e        state_q, state_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic [1:0]        err_q, err_d;
  logic [ADDR_W-1:0] addr_q;
  logic              load;
  logic              step_en;
  logic              finished;
  logic [STEP_W-1:0] last_step;
  cmd_step_t         cur;
  logic [DATA_W-1:0] rep_code, rep_reset;

  assign last_step = op_q ? ERASE_LAST : PROG_LAST;
  assign finished  = op_q ? erase_match : prog_match;
  assign cur       = step_lookup(op_q, step_q);

  for (genvar l = 0; l < LANES; l++) begin : g_rep
    assign rep_code[l*LANE_W +: LANE_W]  = {{(LANE_W-8){1'b0}}, cur.code};
    assign rep_reset[l*LANE_W +: LANE_W] = {{(LANE_W-8){1'b0}}, CODE_RESET};
  end

  always_comb begin
    state_d = state_q;
    step_d  = step_q;
    err_d   = err_q;
    load    = 1'b0;
    tmr_clr = 1'b0;
    tmr_inc = 1'b0;
    case (state_q)
      ST_IDLE: if (start) begin
        load    = 1'b1;
        err_d   = ERR_NONE;
        step_d  = '0;
        state_d = op_erase ? ST_CMD : ST_PRE_RD;
      end
      ST_PRE_RD:  state_d = ST_PRE_CHK;
      ST_PRE_CHK: begin
        if (erased_ok) state_d = ST_CMD;
        else begin
          err_d   = ERR_NOT_ERASED;
          state_d = ST_FIN;
        end
      end
      ST_CMD: begin
        if (step_q == last_step) begin
          tmr_clr = 1'b1;
          state_d = ST_POLL_RD;
        end else begin
          step_d = step_q + STEP_W'(1);
        end
      end
      ST_POLL_RD: state_d = ST_POLL_CHK;
      ST_POLL_CHK: begin
        if (finished) begin
          state_d = op_q ? ST_RST_WR : ST_FIN;
        end else if (last_poll) begin
          err_d   = ERR_TIMEOUT;
          state_d = ST_RST_WR;
        end else begin
          tmr_inc = 1'b1;
          state_d = ST_POLL_RD;
        end
      end
      ST_RST_WR: state_d = ST_FIN;
      ST_FIN:    state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  assign step_en = load | (state_q == ST_CMD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      err_q   <= ERR_NONE;
    end else begin
      state_q <= state_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       step_q <= '0;
    else if (step_en) step_q <= step_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else if (load) begin
      op_q   <= op_erase;
      addr_q <= tgt_addr;
      data_q <= tgt_data;
    end
  end

  always_comb begin
    fl_addr  = addr_q;
    fl_wdata = '0;
    if (state_q == ST_CMD) begin
      case (cur.asel)
        AS_CYC1: fl_addr = CYC1_ADDR;
        AS_CYC2: fl_addr = CYC2_ADDR;
        default: fl_addr = addr_q;
      endcase
      fl_wdata = cur.use_data ? data_q : rep_code;
    end else if (state_q == ST_RST_WR) begin
      fl_wdata = rep_reset;
    end
  end

  assign fl_we    = (state_q == ST_CMD) || (state_q == ST_RST_WR);
  assign fl_re    = (state_q == ST_PRE_RD) || (state_q == ST_POLL_RD);
  assign busy     = (state_q != ST_IDLE) && (state_q != ST_FIN);
  assign done     = (state_q == ST_FIN);
  assign err_code = err_q;
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq #(
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned LANE_W      = 16,
  parameter logic [ADDR_W-1:0] CYC1_ADDR = 'h0555,
  parameter logic [ADDR_W-1:0] CYC2_ADDR = 'h02AA,
  parameter int unsigned PROG_LIMIT  = 1024,
  parameter int unsigned ERASE_LIMIT = 65536
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              op_erase,
  input  logic [ADDR_W-1:0] tgt_addr,
  input  logic [DATA_W-1:0] tgt_data,
  output logic              busy,
  output logic              done,
  output logic [1:0]        err_code,
  output logic [ADDR_W-1:0] fl_addr,
  output logic [DATA_W-1:0] fl_wdata,
  output logic              fl_we,
  output logic              fl_re,
  input  logic [DATA_W-1:0] fl_rdata
);
  localparam int unsigned MAX_LIM = (PROG_LIMIT > ERASE_LIMIT) ? PROG_LIMIT : ERASE_LIMIT;
  localparam int unsigned CNT_W   = $clog2(MAX_LIM + 1);

  logic              rst_sync_n;
  logic              tmr_clr, tmr_inc, last_poll;
  logic              prog_match, erase_match, erased_ok;
  logic              op_q;
  logic [DATA_W-1:0] data_q;
  logic [CNT_W-1:0]  limit;

  assign limit = op_q ? CNT_W'(ERASE_LIMIT) : CNT_W'(PROG_LIMIT);

  fseq_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  fseq_poll_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .clr       (tmr_clr),
    .inc       (tmr_inc),
    .limit     (limit),
    .last_poll (last_poll)
  );

  fseq_lane_check #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_lane (
    .rdata       (fl_rdata),
    .wdata       (data_q),
    .prog_match  (prog_match),
    .erase_match (erase_match),
    .erased_ok   (erased_ok)
  );

  fseq_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANE_W(LANE_W),
    .CYC1_ADDR(CYC1_ADDR), .CYC2_ADDR(CYC2_ADDR)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .start       (start),
    .op_erase    (op_erase),
    .tgt_addr    (tgt_addr),
    .tgt_data    (tgt_data),
    .prog_match  (prog_match),
    .erase_match (erase_match),
    .erased_ok   (erased_ok),
    .last_poll   (last_poll),
    .tmr_clr     (tmr_clr),
    .tmr_inc     (tmr_inc),
    .op_q        (op_q),
    .data_q      (data_q),
    .fl_addr     (fl_addr),
    .fl_wdata    (fl_wdata),
    .fl_we       (fl_we),
    .fl_re       (fl_re),
    .busy        (busy),
    .done        (done),
    .err_code    (err_code)
  );
endmodule

// File: rtl/flash_cmd_seq_chk.sv
module flash_cmd_seq_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LANE_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic [1:0]        err_code,
  input logic              fl_we,
  input logic              fl_re,
  input logic [DATA_W-1:0] fl_wdata
);
  localparam int unsigned LANES = DATA_W / LANE_W;

  logic [DATA_W-1:0] rst_word;
  logic [3:0]        wr_cnt;

  for (genvar l = 0; l < LANES; l++) begin : g_rw
    assign rst_word[l*LANE_W +: LANE_W] = {{(LANE_W-8){1'b0}}, 8'hF0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       wr_cnt <= '0;
    else if (start && !busy && !done) wr_cnt <= '0;
    else if (fl_we)                   wr_cnt <= wr_cnt + 4'd1;
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!fl_we && !fl_re)); // R1

  AST_NOTERASED_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err_code == 2'd2) |-> (wr_cnt == 4'd0)); // R4

  AST_TIMEOUT_RESET_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err_code == 2'd1) |-> ($past(fl_we) && $past(fl_wdata) == rst_word)); // R7

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R10

  AST_ERR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !done && !start) |=> $stable(err_code)); // R10

  AST_NO_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (busy || done)); // R9
endmodule

bind flash_cmd_seq flash_cmd_seq_chk #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .err_code (err_code),
  .fl_we    (fl_we),
  .fl_re    (fl_re),
  .fl_wdata (fl_wdata)
);

// File: tb/flash_cmd_seq_test.sv
module flash_cmd_seq_test;
  localparam int PL = 8;
  localparam int EL = 12;
  localparam logic [15:0] C1 = 16'h0555;
  localparam logic [15:0] C2 = 16'h02AA;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, op_erase = 1'b0;
  logic [15:0] tgt_addr = '0;
  logic [31:0] tgt_data = '0;
  logic busy, done, fl_we, fl_re;
  logic [1:0] err_code;
  logic [15:0] fl_addr;
  logic [31:0] fl_wdata;
  logic [31:0] fl_rdata = '0;

  always #4 clk = ~clk;

  flash_cmd_seq #(.PROG_LIMIT(PL), .ERASE_LIMIT(EL)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_erase(op_erase),
    .tgt_addr(tgt_addr), .tgt_data(tgt_data), .busy(busy), .done(done),
    .err_code(err_code), .fl_addr(fl_addr), .fl_wdata(fl_wdata),
    .fl_we(fl_we), .fl_re(fl_re), .fl_rdata(fl_rdata));

  // behavioural flash array
  logic [31:0] mem [0:63];
  logic        pl_en = 1'b0;
  logic [5:0]  pl_a = '0;
  logic [31:0] pl_v = '0;
  logic        log_clr = 1'b0;
  int          m_delay = 0;
  int          m_busy = 0;
  logic        m_erase = 1'b0;
  logic [31:0] m_pw = '0;
  int          m_st = 0;
  int          n_wr = 0, n_rd = 0, cyc = 0;
  logic [15:0] wa [0:15];
  logic [31:0] wd [0:15];
  int          wc [0:15];

  function automatic logic [31:0] rep(input logic [7:0] b);
    return {8'h00, b, 8'h00, b};
  endfunction

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (pl_en) mem[pl_a] = pl_v;
    if (log_clr) begin n_wr = 0; n_rd = 0; end
    if (fl_re) begin
      n_rd = n_rd + 1;
      if (m_busy > 0) begin
        fl_rdata <= m_erase ? 32'h0 : (m_pw ^ 32'h0080_0080);
        m_busy = m_busy - 1;
      end else fl_rdata <= mem[fl_addr[5:0]];
    end
    if (fl_we) begin
      if (n_wr < 16) begin wa[n_wr] = fl_addr; wd[n_wr] = fl_wdata; wc[n_wr] = cyc; end
      n_wr = n_wr + 1;
      if (fl_wdata == rep(8'hF0)) begin m_busy = 0; m_st = 0; end
      else case (m_st)
        0: m_st = (fl_addr == C1 && fl_wdata == rep(8'hAA)) ? 1 : 0;
        1: m_st = (fl_addr == C2 && fl_wdata == rep(8'h55)) ? 2 : 0;
        2: m_st = (fl_addr == C1 && fl_wdata == rep(8'hA0)) ? 3 :
                  (fl_addr == C1 && fl_wdata == rep(8'h80)) ? 4 : 0;
        3: begin
             mem[fl_addr[5:0]] = mem[fl_addr[5:0]] & fl_wdata;
             m_pw = fl_wdata; m_erase = 1'b0; m_busy = m_delay; m_st = 0;
           end
        4: m_st = (fl_addr == C1 && fl_wdata == rep(8'hAA)) ? 5 : 0;
        5: m_st = (fl_addr == C2 && fl_wdata == rep(8'h55)) ? 6 : 0;
        6: begin
             if (fl_wdata == rep(8'h30)) begin
               mem[fl_addr[5:0]] = 32'hFFFF_FFFF; m_erase = 1'b1; m_busy = m_delay;
             end
             m_st = 0;
           end
        default: m_st = 0;
      endcase
    end
  end

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string req, input logic [47:0] act, input logic [47:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [47:0] exp_wr(input logic op, input int i,
                                         input logic [15:0] a, input logic [31:0] d);
    if (!op) case (i)
      0: return {C1, rep(8'hAA)};
      1: return {C2, rep(8'h55)};
      2: return {C1, rep(8'hA0)};
      3: return {a, d};
      default: return {a, rep(8'hF0)};
    endcase
    case (i)
      0: return {C1, rep(8'hAA)};
      1: return {C2, rep(8'h55)};
      2: return {C1, rep(8'h80)};
      3: return {C1, rep(8'hAA)};
      4: return {C2, rep(8'h55)};
      5: return {a, rep(8'h30)};
      default: return {a, rep(8'hF0)};
    endcase
  endfunction

  typedef struct packed {
    logic        op;
    logic [15:0] addr;
    logic [31:0] data;
    logic [31:0] init;
    logic [7:0]  dly;
    logic [1:0]  err;
    logic [3:0]  nwr;
  } vec_t;

  localparam vec_t VECS [10] = '{
    '{1'b0, 16'h0010, 32'h1234_5678, 32'hFFFF_FFFF, 8'd3,  2'd0, 4'd4},
    '{1'b0, 16'h0011, 32'h0001_0001, 32'h0000_0000, 8'd0,  2'd2, 4'd0},
    '{1'b0, 16'h0012, 32'hA5A5_A5A5, 32'hFFFF_FFFF, 8'd8,  2'd1, 4'd5},
    '{1'b0, 16'h0013, 32'h5A5A_5A5A, 32'hFFFF_FFFF, 8'd7,  2'd0, 4'd4},
    '{1'b1, 16'h0020, 32'h0000_0000, 32'h0000_0000, 8'd5,  2'd0, 4'd7},
    '{1'b1, 16'h0021, 32'h0000_0000, 32'h0000_0000, 8'd12, 2'd1, 4'd7},
    '{1'b1, 16'h0022, 32'h0000_0000, 32'h0000_0000, 8'd11, 2'd0, 4'd7},
    '{1'b0, 16'h0014, 32'h0F00_0F00, 32'h0F0F_0F0F, 8'd0,  2'd0, 4'd4},
    '{1'b0, 16'h0015, 32'h0080_0080, 32'hFFFF_FFFF, 8'd2,  2'd0, 4'd4},
    '{1'b0, 16'h0016, 32'h00FF_0000, 32'h00FE_0000, 8'd0,  2'd2, 4'd0}
  };

  task automatic preload(input logic [5:0] a, input logic [31:0] v);
    @(negedge clk); pl_en = 1'b1; pl_a = a; pl_v = v;
    @(negedge clk); pl_en = 1'b0;
  endtask

  task automatic run_op(input logic op, input logic [15:0] a, input logic [31:0] d,
                        input int stray_at, output bit seen);
    @(negedge clk);
    log_clr = 1'b1; op_erase = op; tgt_addr = a; tgt_data = d; start = 1'b1;
    @(negedge clk);
    log_clr = 1'b0; start = 1'b0;
    seen = 1'b0;
    for (int k = 0; k < 300; k++) begin
      if (done) begin seen = 1'b1; break; end
      if (k == stray_at) begin
        op_erase = ~op; tgt_addr = a + 16'd1; start = 1'b1;
      end
      @(negedge clk);
      start = 1'b0;
    end
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    bit seen;
    string tag;
    int exp_rd, polls, lim, nseq;
    repeat (3) @(negedge clk);
    chk(!busy && !done && err_code == 2'd0 && !fl_we && !fl_re, "R1 in reset",
        {busy, done, err_code, fl_we, fl_re}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!busy && !done && err_code == 2'd0 && !fl_we && !fl_re, "R1 after reset",
        {busy, done, err_code, fl_we, fl_re}, 0);

    for (int v = 0; v < 10; v++) begin
      preload(VECS[v].addr[5:0], VECS[v].init);
      m_delay = int'(VECS[v].dly);
      run_op(VECS[v].op, VECS[v].addr, VECS[v].data, -1, seen);
      lim = VECS[v].op ? EL : PL;
      tag = (VECS[v].err == 2'd2) ? "R4" : (VECS[v].err == 2'd1) ? "R7" :
            VECS[v].op ? "R6" : "R5";
      chk(seen, tag, seen, 1);
      chk(err_code == VECS[v].err, tag, err_code, VECS[v].err);
      chk(n_wr == int'(VECS[v].nwr), tag, n_wr, VECS[v].nwr);
      chk(!busy, "R10 busy low at done", busy, 0);
      nseq = VECS[v].op ? 6 : 4;
      for (int i = 0; i < int'(VECS[v].nwr) && i < 16; i++) begin
        chk({wa[i], wd[i]} == exp_wr(VECS[v].op, i, VECS[v].addr, VECS[v].data),
            VECS[v].op ? "R3 write word" : "R2 write word",
            {wa[i], wd[i]}, exp_wr(VECS[v].op, i, VECS[v].addr, VECS[v].data));
        if (i < nseq)
          chk(wc[i] == wc[0] + i, VECS[v].op ? "R3 back-to-back" : "R2 back-to-back",
              wc[i], wc[0] + i);
      end
      polls  = (int'(VECS[v].dly) + 1 < lim) ? int'(VECS[v].dly) + 1 : lim;
      exp_rd = (VECS[v].err == 2'd2) ? 1 : (VECS[v].op ? polls : polls + 1);
      chk(n_rd == exp_rd, (int'(VECS[v].dly) == lim - 1) ? "R8 poll count" : "R7 poll count",
          n_rd, exp_rd);
      @(negedge clk);
      chk(!done, "R10 done single cycle", done, 0);
    end

    // err_code held while idle
    repeat (5) @(negedge clk);
    chk(err_code == 2'd2, "R10 err held", err_code, 2);

    // stray start while busy
    preload(6'h30, 32'hFFFF_FFFF);
    preload(6'h31, 32'h1234_0000);
    m_delay = 4;
    run_op(1'b0, 16'h0030, 32'h0000_1111, 3, seen);
    chk(seen && err_code == 2'd0, "R9 op completes", err_code, 0);
    chk(n_wr == 4, "R9 no extra write", n_wr, 4);
    repeat (4) @(negedge clk);
    chk(!busy && n_wr == 4 && mem[6'h31] == 32'h1234_0000, "R9 nothing started",
        {busy, n_wr[7:0]}, 4);

    // asynchronous reset mid-operation
    m_delay = 20;
    preload(6'h32, 32'hFFFF_FFFF);
    @(negedge clk); op_erase = 1'b0; tgt_addr = 16'h0032; tgt_data = 32'h0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(!busy && !done && !fl_we && !fl_re, "R1 async reset",
        {busy, done, fl_we, fl_re}, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!busy && err_code == 2'd0, "R1 after second reset", {busy, err_code}, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule